// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system reach an asynchronous, byte-wide static RAM with 19 address lines. A requester raises `req` for one cycle with a read/write flag, an address and a write byte. The block replies with a single-cycle `ready`. On a read, the captured byte appears on `rdata` in the same cycle as `ready`. While an access is in flight, `busy` is high and any further request is dropped.

On the memory side the block drives the address, the active-low chip, write and output enables, and a tri-stated data bus. Every memory timing limit is a nanosecond parameter. Each one becomes a whole number of clock cycles, rounded up, using the clock period parameter `CLK_NS`.

The write sequence keeps the output enable high throughout. The bus is driven only once the memory's outputs have had time to float. The address is moved only while chip enable and write enable are both high.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and after its release, chip enable, write enable and output enable are high, the data bus is not driven, and `ready` and `busy` are low.
- R2: A read holds chip enable and output enable low, with write enable high, for exactly ceil(max(T_RC,T_AA,T_OE)/CLK_NS) cycles. The byte on the bus is captured into `rdata` on the edge that ends this window, and `ready` rises on that same edge. Counting from the edge that accepts `req`, `ready` is high after that many cycles plus 2.
- R3: A write holds chip enable and write enable low together for exactly ceil(max(T_WP,T_AW,T_CW)/CLK_NS) cycles, or for HZ+DW cycles if that is larger. Output enable stays high for the whole write.
- R4: During a write, the block starts driving the bus HZ = ceil(T_HZ/CLK_NS) cycles after write enable falls. It drives for at least DW = ceil(T_DW/CLK_NS) cycles before write enable rises. It keeps driving through the recovery cycles and has released the bus when `ready` is seen.
- R5: A write has a recovery phase of max(1, ceil(T_WC/CLK_NS) − low cycles) cycles with all strobes high. The write cycle therefore lasts at least T_WC. `ready` follows the accepting edge by low plus recovery plus 2 cycles.
- R6: The memory address changes only in a cycle whose chip enable and write enable are high, with both also high in the cycle before.
- R7: Chip enable falls only after a cycle in which all strobes were high and the address already held its new value. With `req` held high, consecutive `ready` pulses of back-to-back reads are read-window plus 2 cycles apart.
- R8: A request that arrives while `busy` is high is ignored. It produces no `ready` and no memory write.
- R9: `ready` lasts exactly one cycle.
- R10: Each cycle count is rounded up to a whole cycle and is at least 1. With a 5 ns clock, a 22 ns float time gives HZ = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Byte to write |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read byte |
| busy | output | 1 | Access in progress |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DATA_W | Bidirectional memory data bus |

## Verification
The hardest situation to provoke from the ports is a second request landing in the middle of an access. It must leave no trace: no extra `ready` and no stray write. The bench raises a write request a few cycles into a read and counts `ready` pulses. It then reads the targeted address back and expects the byte written there earlier.

The write-bus timing is equally hidden. A pulled-up bus model lets the bench see, cycle by cycle, when the block starts and stops driving relative to write enable. The sweep is run with a float time that does not divide the clock period, so the rounding is exercised at its edge.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 5,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 30,
  parameter int T_WC   = 55,
  parameter int T_WP   = 45,
  parameter int T_AW   = 50,
  parameter int T_CW   = 50,
  parameter int T_DW   = 25,
  parameter int T_HZ   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_A   = (cyc(T_AA) > cyc(T_OE)) ? cyc(T_AA) : cyc(T_OE);
  localparam int RD_CYC = (RD_A > cyc(T_RC)) ? RD_A : cyc(T_RC);
  localparam int HZ_CYC = cyc(T_HZ);
  localparam int WL_A   = (cyc(T_WP) > cyc(T_AW)) ? cyc(T_WP) : cyc(T_AW);
  localparam int WL_B   = (WL_A > cyc(T_CW)) ? WL_A : cyc(T_CW);
  localparam int WL_CYC = (WL_B > HZ_CYC + cyc(T_DW)) ? WL_B : HZ_CYC + cyc(T_DW);
  localparam int RC_CYC = (cyc(T_WC) - WL_CYC > 1) ? cyc(T_WC) - WL_CYC : 1;
  localparam int MAXC_A = (RD_CYC > WL_CYC) ? RD_CYC : WL_CYC;
  localparam int MAXC   = (MAXC_A > RC_CYC) ? MAXC_A : RC_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RD, S_WR, S_REC} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic                wr_q;
  logic                drv;
  logic [DATA_W-1:0]   d_q;

  assign busy   = (state != S_IDLE);
  assign mem_dq = drv ? d_q : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      drv      <= 1'b0;
      d_q      <= '0;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      ready    <= 1'b0;
      rdata    <= '0;
    end else begin
      ready <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          d_q      <= wdata;
          wr_q     <= wr;
          state    <= S_ADDR;
        end
        S_ADDR: begin
          cnt      <= '0;
          mem_ce_n <= 1'b0;
          if (wr_q) begin
            mem_we_n <= 1'b0;
            state    <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= S_RD;
          end
        end
        S_RD: begin
          if (cnt == CNT_W'(RD_CYC - 1)) begin
            rdata    <= mem_dq;
            ready    <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_WR: begin
          if (cnt == CNT_W'(HZ_CYC - 1)) drv <= 1'b1;
          if (cnt == CNT_W'(WL_CYC - 1)) begin
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
            cnt      <= '0;
            state    <= S_REC;
          end else cnt <= cnt + 1'b1;
        end
        S_REC: begin
          if (cnt == CNT_W'(RC_CYC - 1)) begin
            drv   <= 1'b0;
            ready <= 1'b1;
            state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_drive_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !drv);
  p_drive_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> mem_oe_n && (state == S_WR || state == S_REC));
  p_addr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n));
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int AW   = 6;
  localparam int CLK  = 5;
  localparam int E_RD  = 11;
  localparam int E_HZ  = 5;
  localparam int E_DW  = 5;
  localparam int E_WL  = 10;
  localparam int E_REC = 1;
  localparam int E_RLAT = E_RD + 2;
  localparam int E_WLAT = E_WL + E_REC + 2;

  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, busy, ce_n, we_n, oe_n;
  logic [7:0] rdata;
  logic [AW-1:0] maddr;
  tri1 [7:0] dq;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CLK), .T_HZ(22)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .busy(busy), .mem_addr(maddr),
    .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq(dq));

  logic [7:0] mem [64];
  assign dq = (!ce_n && !oe_n && we_n) ? mem[maddr] : 8'bz;

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  int ce_run = 0, we_run = 0, drv_first = -1, drv_cnt = 0;
  bit oe_bad = 0;
  logic prev_ce = 1, prev_we = 1;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) if (rst_n) begin
    automatic bit driven = (dq != 8'hFF);
    if (maddr != prev_addr)
      chk(ce_n && we_n && prev_ce && prev_we, "R6 address moved with strobe low", {ce_n, we_n}, 3);
    if (!ce_n && prev_ce)
      chk(maddr == prev_addr, "R7 address settled before select", int'(maddr), int'(prev_addr));
    if (!ce_n) begin
      ce_run++;
      if (!we_n) begin
        we_run++;
        if (!oe_n) oe_bad = 1;
        if (driven) begin
          if (drv_cnt == 0) drv_first = we_run - 1;
          drv_cnt++;
          mem[maddr] = dq;
        end
      end
    end else if (ce_run > 0) begin
      if (we_run > 0) begin
        chk(ce_run == E_WL, "R3 select window", ce_run, E_WL);
        chk(we_run == E_WL, "R3 write strobe window", we_run, E_WL);
        chk(!oe_bad, "R3 output enable high", oe_bad, 0);
        chk(drv_first == E_HZ, "R4 R10 drive start", drv_first, E_HZ);
        chk(drv_cnt == E_WL - E_HZ && drv_cnt >= E_DW, "R4 setup", drv_cnt, E_WL - E_HZ);
        chk(driven, "R4 hold in recovery", driven, 1);
      end else begin
        chk(ce_run == E_RD, "R2 read window", ce_run, E_RD);
      end
      ce_run = 0; we_run = 0; drv_first = -1; drv_cnt = 0; oe_bad = 0;
    end
    prev_ce = ce_n; prev_we = we_n; prev_addr = maddr;
  end

  task automatic access(input bit w, input int a, input logic [7:0] d,
                        output logic [7:0] r, output int lat);
    @(negedge clk); req = 1; wr = w; addr = AW'(a); wdata = d;
    @(negedge clk); req = 0; lat = 1;
    chk(!ready, "R2 no early ready", ready, 0);
    while (!ready && lat < 100) begin @(negedge clk); lat++; end
    r = rdata;
    if (w) chk(dq == 8'hFF, "R4 bus released", int'(dq), 255);
    @(negedge clk);
    chk(!ready, "R9 ready one cycle", ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int lat, n, t1, t2;
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 7);
    chk(dq == 8'hFF && !ready && !busy, "R1 idle in reset", int'(dq), 255);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(ce_n && we_n && oe_n && !busy && !ready, "R1 after reset", {ce_n, we_n, oe_n}, 7);

    for (int a = 0; a < 64; a++) begin
      access(1, a, pat(a), r, lat);
      chk(lat == E_WLAT, "R5 write latency", lat, E_WLAT);
    end
    for (int a = 63; a >= 0; a--) begin
      access(0, a, 8'h00, r, lat);
      chk(lat == E_RLAT, "R2 read latency", lat, E_RLAT);
      chk(r == pat(a), "R2 read data", int'(r), int'(pat(a)));
    end

    // R8: write request while a read is running
    @(negedge clk); req = 1; wr = 0; addr = 6'd3;
    @(negedge clk); req = 0;
    repeat (2) @(negedge clk);
    req = 1; wr = 1; addr = 6'd9; wdata = ~pat(9);
    @(negedge clk); req = 0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (ready) begin
        n++;
        chk(rdata == pat(3), "R8 first read intact", int'(rdata), int'(pat(3)));
      end
      @(negedge clk);
    end
    chk(n == 1, "R8 one ready only", n, 1);
    access(0, 9, 8'h00, r, lat);
    chk(r == pat(9), "R8 no stray write", int'(r), int'(pat(9)));

    // R7: back-to-back reads with req held
    @(negedge clk); req = 1; wr = 0; addr = 6'd20;
    n = 0; t1 = 0; t2 = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (ready) begin
        n++;
        if (n == 1) t1 = i;
        if (n == 2) begin t2 = i; req = 0; end
        chk(rdata == pat(20), "R7 back-to-back data", int'(rdata), int'(pat(20)));
      end
    end
    req = 0;
    chk(t2 - t1 == E_RD + 2, "R7 idle gap between accesses", t2 - t1, E_RD + 2);
    repeat (20) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule